// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block lets a small processor core run single read and write cycles on an external bus whose low address byte and data byte share one eight-bit path. The core raises a one-clock request with a 16-bit address, a write flag and write data. The block sequences the external pins and returns a one-clock completion pulse, with the captured byte on a read. The upper address byte leaves on its own port and stays stable for the whole cycle. An active-low address strobe tells the external side when the shared path holds an address. An active-low data strobe marks when the path carries data.

Every external cycle is built from bus states. Each state lasts two clocks: a first half and a second half. A basic cycle is T1 (address), T2 (data strobe falls), then T3 (data strobe rises, completion). The cycle can be stretched in two ways. A per-request extended-timing flag adds a fixed number of forced data states, called TX. A sampled active-low wait input adds one wait state, TW, for each low sample.

Top module: `xbus_ctrl`

## Requirements
- R1: During the two T1 clocks `ad_o` carries `addr_i[7:0]` with `ad_oe_o` high, and throughout the cycle `a_hi_o` equals `addr_i[15:8]` of the accepted request.
- R2: `as_n_o` is low for exactly the first clock of a cycle and high in every other clock. `ad_oe_o` is high and `rw_o` is already valid in that clock, and the address stays on `ad_o` for the clock after the strobe rises.
- R3: On a read (`we_i`=0), `ad_oe_o` is low from the first clock of T2 to the end of the cycle. `ds_n_o` falls one clock later, in the second clock of T2.
- R4: On a read, the value on `ad_i` in the last clock before `ds_n_o` rises is captured. It is presented on `rdata_o` in the completion clock and held until the next read.
- R5: On a write (`we_i`=1), `ad_o` carries the write data with `ad_oe_o` high from the first clock of T2 through the first clock of T3, one clock after `ds_n_o` rises. `rw_o` is 0 for the whole cycle and is 1 otherwise.
- R6: With no extension and no wait, a cycle lasts 6 clocks from the clock after acceptance. `ds_n_o` is low only in clock 3 (counting from 0), and `done_o` is high only in clock 5.
- R7: `wait_n_i` is sampled at the end of the second clock of T2, or of the last TX state, and of each TW state. Each low sample inserts one TW state of 2 clocks, during which `ds_n_o` stays low.
- R8: When `ext_time_i` is 1 at acceptance, EXT_STATES (default 2) TX states of 2 clocks each follow T2 with `ds_n_o` low. `wait_n_i` is not sampled inside them, and a low wait there adds nothing.
- R9: While idle, `ad_oe_o`=0, `as_n_o`=1, `ds_n_o`=1, `rw_o`=1 and `done_o`=0, and a low `wait_n_i` has no effect.
- R10: `done_o` is high for exactly one clock, the last clock of T3. A request raised during a cycle is ignored, and no address strobe follows completion until a new request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | One-clock cycle request, taken only while idle |
| addr_i | input | 16 | Cycle address |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 8 | Write data |
| ext_time_i | input | 1 | Add the extended-timing states to this cycle |
| rdata_o | output | 8 | Captured read data |
| done_o | output | 1 | One-clock completion pulse |
| ad_o | output | 8 | Shared address/data bus, outgoing value |
| ad_i | input | 8 | Shared address/data bus, incoming value |
| ad_oe_o | output | 1 | Drive enable for the shared bus |
| a_hi_o | output | 8 | Upper address byte |
| as_n_o | output | 1 | Address strobe, active low |
| ds_n_o | output | 1 | Data strobe, active low |
| rw_o | output | 1 | 1 = read, 0 = write |
| wait_n_i | input | 1 | Wait request, active low |

## Verification
The bench sweeps every combination of direction, extended timing off and on, and zero to three wait samples. In each combination it predicts every pin on every clock from the cycle length formula. The sweep separates a stretch caused by the fixed extension from one caused by wait sampling: wait is also held low inside the TX states, where it must add nothing. The read data on the shared bus changes value except in the single capture clock, which shows that the capture comes from the right edge. Separate runs keep wait low while idle and raise a second request mid-cycle, and neither may start or alter a cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_T1   = 3'd1,
      S_T2   = 3'd2,
      S_TX   = 3'd3,
      S_TW   = 3'd4,
      S_T3   = 3'd5
   } bstate_e;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int EXT_STATES = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req,
   input  logic    ext,
   input  logic    wait_n,
   output bstate_e st,
   output logic    ph,
   output logic    accept,
   output logic    cap,
   output logic    done
);
   localparam int CW = (EXT_STATES > 1) ? $clog2(EXT_STATES) : 1;

   if (EXT_STATES < 0 || EXT_STATES > 15) begin : g_bad_ext
      $error("xbus_seq: EXT_STATES must lie in 0..15");
   end

   bstate_e st_q, st_d;
   logic    ph_q, ph_d;
   logic    ext_on;
   logic    last_x;

   if (EXT_STATES > 0) begin : g_ext
      logic          ext_q;
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ext_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            if (accept) ext_q <= ext;
            if (st_q != S_TX)  cnt_q <= '0;
            else if (ph_q)     cnt_q <= cnt_q + 1'b1;
         end
      end
      assign ext_on = ext_q;
      assign last_x = (cnt_q == CW'(EXT_STATES - 1));
   end else begin : g_noext
      assign ext_on = 1'b0;
      assign last_x = 1'b1;
   end

   always_comb begin
      st_d = st_q;
      ph_d = (st_q == S_IDLE) ? 1'b0 : ~ph_q;
      unique case (st_q)
         S_IDLE: if (req) st_d = S_T1;
         S_T1:   if (ph_q) st_d = S_T2;
         S_T2:   if (ph_q) st_d = ext_on ? S_TX : (wait_n ? S_T3 : S_TW);
         S_TX:   if (ph_q && last_x) st_d = wait_n ? S_T3 : S_TW;
         S_TW:   if (ph_q && wait_n) st_d = S_T3;
         S_T3:   if (ph_q) st_d = S_IDLE;
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= S_IDLE;
         ph_q <= 1'b0;
      end else begin
         st_q <= st_d;
         ph_q <= ph_d;
      end
   end

   assign accept = (st_q == S_IDLE) && req;
   assign cap    = (st_q != S_T3) && (st_d == S_T3);
   assign done   = (st_q == S_T3) && ph_q;
   assign st     = st_q;
   assign ph     = ph_q;

   // R9: a low wait while idle never starts a cycle
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_IDLE && !req) |=> (st_q == S_IDLE));
   // R7: a low wait sample keeps the bus in a wait state
   p_wait_stretch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_TW && ph_q && !wait_n) |=> (st_q == S_TW));
   // R10: completion returns to idle
   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (st_q == S_IDLE));
endmodule

// File: rtl/xbus_dp.sv
module xbus_dp #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              cap,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] ad_i,
   output logic [ADDR_W-1:0] addr_q,
   output logic              we_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         we_q    <= 1'b0;
         wdata_q <= '0;
         rdata_o <= '0;
      end else begin
         if (accept) begin
            addr_q  <= addr_i;
            we_q    <= we_i;
            wdata_q <= wdata_i;
         end
         if (cap && !we_q) rdata_o <= ad_i;
      end
   end

   // R4: read data only changes at the capture point
   p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(rdata_o));
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
   import xbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  bstate_e                  st,
   input  logic                     ph,
   input  logic [ADDR_W-1:0]        addr_q,
   input  logic                     we_q,
   input  logic [DATA_W-1:0]        wdata_q,
   output logic [DATA_W-1:0]        ad_o,
   output logic                     ad_oe_o,
   output logic [ADDR_W-DATA_W-1:0] a_hi_o,
   output logic                     as_n_o,
   output logic                     ds_n_o,
   output logic                     rw_o
);
   always_comb begin
      as_n_o  = 1'b1;
      ds_n_o  = 1'b1;
      ad_oe_o = 1'b0;
      rw_o    = 1'b1;
      ad_o    = wdata_q;
      unique case (st)
         S_IDLE: ;
         S_T1: begin
            as_n_o  = ph;
            ad_oe_o = 1'b1;
            ad_o    = addr_q[DATA_W-1:0];
            rw_o    = ~we_q;
         end
         S_T2: begin
            ds_n_o  = ~ph;
            ad_oe_o = we_q;
            rw_o    = ~we_q;
         end
         S_TX, S_TW: begin
            ds_n_o  = 1'b0;
            ad_oe_o = we_q;
            rw_o    = ~we_q;
         end
         S_T3: begin
            ad_oe_o = we_q & ~ph;
            rw_o    = ~we_q;
         end
         default: ;
      endcase
   end
   assign a_hi_o = addr_q[ADDR_W-1:DATA_W];

   // R2: the two strobes are never low together
   p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !as_n_o |-> ds_n_o);
   // R1: the address strobe only falls while the bus is driven
   p_as_driven_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(as_n_o) |-> ad_oe_o);
   // R3: the bus floats while the data strobe is low on a read
   p_read_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ds_n_o && rw_o) |-> !ad_oe_o);
   // R5: the direction level does not move as the data strobe rises
   p_rw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ds_n_o) |-> $stable(rw_o));
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
   import xbus_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int EXT_STATES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_i,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic                     we_i,
   input  logic [DATA_W-1:0]        wdata_i,
   input  logic                     ext_time_i,
   output logic [DATA_W-1:0]        rdata_o,
   output logic                     done_o,
   output logic [DATA_W-1:0]        ad_o,
   input  logic [DATA_W-1:0]        ad_i,
   output logic                     ad_oe_o,
   output logic [ADDR_W-DATA_W-1:0] a_hi_o,
   output logic                     as_n_o,
   output logic                     ds_n_o,
   output logic                     rw_o,
   input  logic                     wait_n_i
);
   if (ADDR_W <= DATA_W || DATA_W < 1) begin : g_bad_w
      $error("xbus_ctrl: ADDR_W must exceed DATA_W");
   end

   bstate_e           st;
   logic              ph, accept, cap;
   logic [ADDR_W-1:0] addr_q;
   logic              we_q;
   logic [DATA_W-1:0] wdata_q;

   xbus_seq #(.EXT_STATES(EXT_STATES)) u_seq (
      .clk(clk), .rst_n(rst_n), .req(req_i), .ext(ext_time_i),
      .wait_n(wait_n_i), .st(st), .ph(ph), .accept(accept),
      .cap(cap), .done(done_o)
   );

   xbus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk(clk), .rst_n(rst_n), .accept(accept), .cap(cap),
      .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i), .ad_i(ad_i),
      .addr_q(addr_q), .we_q(we_q), .wdata_q(wdata_q), .rdata_o(rdata_o)
   );

   xbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
      .clk(clk), .rst_n(rst_n), .st(st), .ph(ph), .addr_q(addr_q),
      .we_q(we_q), .wdata_q(wdata_q), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
      .a_hi_o(a_hi_o), .as_n_o(as_n_o), .ds_n_o(ds_n_o), .rw_o(rw_o)
   );

   // R10: no address strobe right after completion
   p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> as_n_o);
   // R6: the completion clock has the data strobe high
   p_done_ds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ds_n_o);
endmodule

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int EXT_ST     = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, we = 1'b0, ext = 1'b0, wait_n = 1'b1;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0, ad_in = '0;
   logic [7:0]  rdata, ad_out, a_hi;
   logic        done, oe, as_n, ds_n, rw;
   int          checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xbus_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr), .we_i(we),
      .wdata_i(wdata), .ext_time_i(ext), .rdata_o(rdata), .done_o(done),
      .ad_o(ad_out), .ad_i(ad_in), .ad_oe_o(oe), .a_hi_o(a_hi),
      .as_n_o(as_n), .ds_n_o(ds_n), .rw_o(rw), .wait_n_i(wait_n)
   );

   task automatic chk(input string req_tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req_tag, what, act, exp);
      end
   endtask

   // R9 idle pins
   task automatic chk_idle(input string tag);
      chk(tag, "idle oe/as/ds/rw/done", {11'd0, oe, as_n, ds_n, rw, done},
          {11'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0});
   endtask

   task automatic run_cycle(input logic w_e, input logic x, input int nw,
                            input logic [15:0] a, input logic [7:0] d,
                            input bit busy_req);
      int e  = x ? 2*EXT_ST : 0;
      int n  = 6 + e + 2*nw;
      logic [7:0] rpat = d ^ 8'h5A;
      @(negedge clk);
      addr = a; we = w_e; wdata = d; ext = x; req = 1'b1; wait_n = 1'b1;
      @(posedge clk);
      for (int i = 0; i < n; i++) begin
         logic e_as, e_ds, e_oe, e_rw, e_done;
         logic [7:0] e_ad;
         @(negedge clk);
         req    = busy_req && (i == 2);
         addr   = busy_req ? ~a : a;
         wait_n = !(i >= 2 && i < 3 + e + 2*nw);
         ad_in  = (i == n - 3) ? rpat : ~rpat;
         e_as   = (i != 0);
         e_ds   = !(i >= 3 && i < n - 2);
         e_oe   = w_e ? (i <= n - 2) : (i < 2);
         e_rw   = ~w_e;
         e_done = (i == n - 1);
         e_ad   = (i < 2) ? a[7:0] : d;
         // R2 R6 R7 R8 R10 strobe/done timing
         chk("R2/R6/R7/R8/R10", $sformatf("strobes w=%0d x=%0d nw=%0d t=%0d", w_e, x, nw, i),
             {13'd0, as_n, ds_n, done}, {13'd0, e_as, e_ds, e_done});
         // R3 R5 drive enable and direction
         chk("R3/R5", $sformatf("oe/rw t=%0d", i), {14'd0, oe, rw}, {14'd0, e_oe, e_rw});
         // R1 high address byte
         chk("R1", $sformatf("a_hi t=%0d", i), {8'd0, a_hi}, {8'd0, a[15:8]});
         if (e_oe) chk("R1/R5", $sformatf("bus value t=%0d", i), {8'd0, ad_out}, {8'd0, e_ad});
         if (!w_e && e_done) chk("R4", "read data", {8'd0, rdata}, {8'd0, rpat});
      end
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         req = 1'b0; wait_n = 1'b0;
         chk_idle("R10 after done");
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_idle("R9 reset");
      rst_n = 1'b1;
      // R9: wait low while idle starts nothing
      wait_n = 1'b0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk_idle("R9 wait idle");
      end
      for (int x = 0; x < 2; x++)
         for (int nw = 0; nw < 4; nw++)
            for (int w_e = 0; w_e < 2; w_e++) begin
               int idx = x*8 + nw*2 + w_e;
               run_cycle(w_e[0], x[0], nw, 16'h1234 + 16'(idx) * 16'h0F31,
                         8'h3C + 8'(idx * 7), 1'b0);
            end
      // R10: request mid-cycle is ignored
      run_cycle(1'b0, 1'b0, 1, 16'hA55A, 8'h81, 1'b1);
      run_cycle(1'b1, 1'b1, 0, 16'h7E01, 8'hC3, 1'b1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule